// File: doc/BRIEF.md
# Audio Clock Regeneration Time-Stamp Counter

This block sits on the transmit side of a digital display link that carries audio. It measures the ratio between the link clock and an audio reference clock running at 128 times the audio sample rate. The sink rebuilds the audio clock from the link clock using the relation 128·fs = f_link · N / CTS. To support that, the block divides the reference clock by a programmable numerator N. It then counts link clock cycles across each divided period. The count is the cycle time stamp (CTS).

The two clocks may be coherent, with a rational relation, or fully asynchronous. The divided edge is carried into the link domain as a toggle that passes through a synchronizer chain. Each detected toggle closes one measurement, and the counter restarts from 1. Each completed measurement is delivered with a one-cycle strobe, together with the N that governed that period, so that a packet builder downstream can send the pair. The first edge after enable only arms the counter and produces no report. A period that would overrun the count width is reported at full scale with an error flag.

Top module: `acr_cts_meter`

## Requirements
- R1: While reset is asserted and after it is released with enable low, `cts` and `n_used` read 0, and `cts_valid` and `cts_err` are low.
- R2: After enable rises, the first divided edge produces no strobe. The first report appears only after two divided edges, at least two divided periods after enable.
- R3: `cts` equals the number of link clock cycles between two consecutive detected divided edges. With a reference of 10 ns, N = 8 and a 4 ns link clock, every report is exactly 20.
- R4: With unrelated clocks, each report is the floor or the ceiling of f_link·N/f_ref. The sum of four consecutive reports is within 1 of four times the exact ratio.
- R5: `cts_valid` is high for exactly one link cycle per report and is never high on two consecutive cycles.
- R6: N is taken only when the divider wraps. A change of `n_value` during a period first affects the following period. `n_used` reports the N that governed the measured period.
- R7: An `n_value` of 0 is treated as 1, and `n_used` reports 1.
- R8: A period longer than 2^CTS_W−1 link cycles is reported as all ones with `cts_err` high. A period of exactly 2^CTS_W−1 cycles reports all ones with `cts_err` low. The flag clears with the next in-range report.
- R9: While enable is low no strobe is produced. Re-enabling discards the first edge again, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Audio reference clock, 128 × sample rate |
| lnk_clk | input | 1 | Link (TMDS) clock; all outputs are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| enable | input | 1 | Measurement enable, link clock domain |
| n_value | input | N_W (20) | Requested divider numerator N, held quasi-static |
| cts | output | CTS_W (20) | Last measured cycle time stamp |
| cts_valid | output | 1 | One-cycle strobe marking a new N/CTS pair |
| cts_err | output | 1 | Last reported period overran the count range |
| n_used | output | N_W (20) | N that governed the reported period |

## Verification
A divided edge reaches the link domain after SYNC_STAGES+1 link cycles. The report strobe rises on the same edge that loads the count. Because of this, the first report after enable falls about two divided periods plus roughly three cycles later. With N = 8 and a 10 ns reference, the first strobe lands near cycle 45. The bench therefore treats cycles 0 to 35 after enable as a window in which no strobe may appear.

Reports are captured by a monitor on the falling link edge. The scenario tasks poll that monitor one nanosecond after the rising edge and compare the captured `cts`, `n_used` and `cts_err` against the expected values. The expected values are: the exact period in link cycles for coherent clocks, a floor/ceiling window for unrelated clocks, and the previous N for the report that straddles a change of N.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned ACR_N_W       = 20;
  localparam int unsigned ACR_CTS_W     = 20;
  localparam int unsigned ACR_SYNC_DEPTH = 2;
endpackage

// File: rtl/acr_sync_chain.sv
// Flop chain that shifts d into the clk domain; clears asynchronously.
module acr_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/acr_ref_divider.sv
// Reference-domain divide-by-N; flips a toggle once per N reference cycles.
module acr_ref_divider #(
  parameter int unsigned N_W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N_W-1:0] n_req,
  output logic           tgl_o,
  output logic [N_W-1:0] n_rep_o
);
  localparam logic [N_W-1:0] N_ONE = N_W'(1);

  logic [N_W-1:0] div_cnt_q, div_cnt_d;
  logic [N_W-1:0] n_cur_q,   n_cur_d;
  logic [N_W-1:0] n_rep_q,   n_rep_d;
  logic           tgl_q,     tgl_d;
  logic [N_W-1:0] n_eff;
  logic           wrap;

  always_comb begin
    n_eff     = (n_req == '0) ? N_ONE : n_req;
    wrap      = en && (div_cnt_q == (n_cur_q - N_ONE));
    div_cnt_d = div_cnt_q;
    n_cur_d   = n_cur_q;
    n_rep_d   = n_rep_q;
    tgl_d     = tgl_q;
    if (!en) begin
      div_cnt_d = '0;
      n_cur_d   = n_eff;
    end else if (wrap) begin
      div_cnt_d = '0;
      n_rep_d   = n_cur_q;
      n_cur_d   = n_eff;
      tgl_d     = ~tgl_q;
    end else begin
      div_cnt_d = div_cnt_q + N_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      n_cur_q   <= N_ONE;
      n_rep_q   <= '0;
      tgl_q     <= 1'b0;
    end else begin
      div_cnt_q <= div_cnt_d;
      n_cur_q   <= n_cur_d;
      n_rep_q   <= n_rep_d;
      tgl_q     <= tgl_d;
    end
  end

  assign tgl_o   = tgl_q;
  assign n_rep_o = n_rep_q;

  // R7: the active divisor is never zero
  a_r7_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    n_cur_q != '0);

  // R6: the divider count never runs past the divisor in use
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> div_cnt_q < n_cur_q);
endmodule

// File: rtl/acr_edge_xfer.sv
// Link-domain toggle synchronizer: one pulse per divided edge, plus N capture.
module acr_edge_xfer #(
  parameter int unsigned N_W    = 20,
  parameter int unsigned STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tgl_i,
  input  logic [N_W-1:0] n_i,
  output logic           pulse_o,
  output logic [N_W-1:0] n_o
);
  logic [STAGES:0] sh_q, sh_d;
  logic [N_W-1:0]  n_q,  n_d;
  logic            edge_seen;

  always_comb begin
    sh_d      = {sh_q[STAGES-1:0], tgl_i};
    edge_seen = sh_q[STAGES] ^ sh_q[STAGES-1];
    n_d       = edge_seen ? n_i : n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      n_q  <= '0;
    end else begin
      sh_q <= sh_d;
      n_q  <= n_d;
    end
  end

  assign pulse_o = edge_seen;
  assign n_o     = n_q;

  // R6: the reported N only moves on a detected edge
  a_r6_n_held_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_o |=> $stable(n_o));
endmodule

// File: rtl/acr_cts_counter.sv
// Link-cycle counter: latches the period on each edge, arms on the first.
module acr_cts_counter #(
  parameter int unsigned CTS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pulse_i,
  output logic [CTS_W-1:0] cts_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam logic [CTS_W-1:0] CNT_MAX = '1;
  localparam logic [CTS_W-1:0] CNT_ONE = CTS_W'(1);

  logic [CTS_W-1:0] cnt_q, cnt_d;
  logic [CTS_W-1:0] cts_q, cts_d;
  logic             sat_q, sat_d;
  logic             armed_q, armed_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d   = cnt_q;
    cts_d   = cts_q;
    sat_d   = sat_q;
    armed_d = armed_q;
    err_d   = err_q;
    valid_d = 1'b0;
    if (!en) begin
      cnt_d   = '0;
      sat_d   = 1'b0;
      armed_d = 1'b0;
    end else if (pulse_i) begin
      cnt_d   = CNT_ONE;
      sat_d   = 1'b0;
      armed_d = 1'b1;
      if (armed_q) begin
        cts_d   = cnt_q;
        err_d   = sat_q;
        valid_d = 1'b1;
      end
    end else if (cnt_q == CNT_MAX) begin
      sat_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cts_q   <= '0;
      sat_q   <= 1'b0;
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cts_q   <= cts_d;
      sat_q   <= sat_d;
      armed_q <= armed_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign cts_o   = cts_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  // R2: the arming edge never produces a report
  a_r2_first_edge_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pulse_i && !armed_q) |=> !valid_o);

  // R8: an overrun report always sits at full scale
  a_r8_err_at_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && err_o) |-> (cts_o == CNT_MAX));

  // R9: no report follows a cycle with enable low
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid_o);

  // R3: a reported period is at least one cycle
  a_r3_cts_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cts_o != '0));
endmodule

// File: rtl/acr_cts_meter.sv
module acr_cts_meter
  import acr_pkg::*;
#(
  parameter int unsigned N_W         = ACR_N_W,
  parameter int unsigned CTS_W       = ACR_CTS_W,
  parameter int unsigned SYNC_STAGES = ACR_SYNC_DEPTH
) (
  input  logic             ref_clk,
  input  logic             lnk_clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [N_W-1:0]   n_value,
  output logic [CTS_W-1:0] cts,
  output logic             cts_valid,
  output logic             cts_err,
  output logic [N_W-1:0]   n_used
);
  logic           ref_rst_n;
  logic           lnk_rst_n;
  logic           en_ref;
  logic           div_tgl;
  logic [N_W-1:0] div_n_rep;
  logic           edge_pulse;

  acr_sync_chain #(.STAGES(SYNC_STAGES)) u_rst_ref (
    .clk(ref_clk), .arst_n(rst_n), .d(1'b1), .q(ref_rst_n));

  acr_sync_chain #(.STAGES(SYNC_STAGES)) u_rst_lnk (
    .clk(lnk_clk), .arst_n(rst_n), .d(1'b1), .q(lnk_rst_n));

  acr_sync_chain #(.STAGES(SYNC_STAGES)) u_en_ref (
    .clk(ref_clk), .arst_n(ref_rst_n), .d(enable), .q(en_ref));

  acr_ref_divider #(.N_W(N_W)) u_div (
    .clk(ref_clk), .rst_n(ref_rst_n), .en(en_ref), .n_req(n_value),
    .tgl_o(div_tgl), .n_rep_o(div_n_rep));

  acr_edge_xfer #(.N_W(N_W), .STAGES(SYNC_STAGES)) u_xfer (
    .clk(lnk_clk), .rst_n(lnk_rst_n), .tgl_i(div_tgl), .n_i(div_n_rep),
    .pulse_o(edge_pulse), .n_o(n_used));

  acr_cts_counter #(.CTS_W(CTS_W)) u_cnt (
    .clk(lnk_clk), .rst_n(lnk_rst_n), .en(enable), .pulse_i(edge_pulse),
    .cts_o(cts), .valid_o(cts_valid), .err_o(cts_err));
endmodule

// File: tb/acr_cts_meter_bench.sv
`timescale 1ns/1ps
module acr_cts_meter_bench;
  localparam int NW  = 20;
  localparam int CW  = 20;
  localparam int SCW = 8;

  logic lnk_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic ref_clk_s = 1'b0;
  logic rst_n = 1'b0;
  realtime ref_half = 5.0;

  always #2 lnk_clk = ~lnk_clk;
  initial begin #0.5; forever #(ref_half) ref_clk = ~ref_clk; end
  initial begin #0.5; forever #5 ref_clk_s = ~ref_clk_s; end

  logic           en_m, en_s;
  logic [NW-1:0]  n_m, n_s, nu_m, nu_s;
  logic [CW-1:0]  cts_m;
  logic [SCW-1:0] cts_s;
  logic           val_m, val_s, err_m, err_s;

  acr_cts_meter u_acr_cts_meter (
    .ref_clk(ref_clk), .lnk_clk(lnk_clk), .rst_n(rst_n), .enable(en_m),
    .n_value(n_m), .cts(cts_m), .cts_valid(val_m), .cts_err(err_m),
    .n_used(nu_m));

  acr_cts_meter #(.CTS_W(SCW)) u_acr_cts_meter_sat (
    .ref_clk(ref_clk_s), .lnk_clk(lnk_clk), .rst_n(rst_n), .enable(en_s),
    .n_value(n_s), .cts(cts_s), .cts_valid(val_s), .cts_err(err_s),
    .n_used(nu_s));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge lnk_clk) cyc++;

  int str_m = 0, str_s = 0, dbl = 0;
  longint lc_m, ln_m, le_m, lc_s, ln_s, le_s;
  logic pv_m = 1'b0, pv_s = 1'b0;

  always @(negedge lnk_clk) begin
    if (val_m) begin
      str_m++; lc_m = cts_m; ln_m = nu_m; le_m = err_m;
      if (pv_m) dbl++;
    end
    if (val_s) begin
      str_s++; lc_s = cts_s; ln_s = nu_s; le_s = err_s;
      if (pv_s) dbl++;
    end
    pv_m = val_m;
    pv_s = val_s;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input longint act, input longint exp, input string msg);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic chk_rng(input longint act, input longint lo, input longint hi,
                         input string msg);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", msg, act, lo, hi);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge lnk_clk);
    #1;
  endtask

  task automatic wait_m(input string tag);
    int s0 = str_m;
    int k = 0;
    while (str_m == s0 && k < 3000) begin step(1); k++; end
    if (str_m == s0) chk(0, 1, {tag, " report timeout"});
  endtask

  task automatic wait_s(input string tag);
    int s0 = str_s;
    int k = 0;
    while (str_s == s0 && k < 3000) begin step(1); k++; end
    if (str_s == s0) chk(0, 1, {tag, " report timeout"});
  endtask

  task automatic t_reset();
    chk(cts_m, 0, "R1 cts after reset");
    chk(nu_m, 0, "R1 n_used after reset");
    chk(val_m, 0, "R1 strobe after reset");
    chk(err_m, 0, "R1 error after reset");
  endtask

  task automatic t_first();
    int s0, t0;
    n_m = 8;
    en_m = 1'b1;
    t0 = cyc;
    s0 = str_m;
    step(35);
    chk(str_m - s0, 0, "R2 no report on arming edge");
    wait_m("R2");
    chk_rng(cyc - t0, 40, 60, "R2 first report after two divided periods");
    chk(lc_m, 20, "R3 coherent period 1");
    chk(ln_m, 8, "R3 n_used with report");
    wait_m("R3");
    chk(lc_m, 20, "R3 coherent period 2");
    wait_m("R3");
    chk(lc_m, 20, "R3 coherent period 3");
  endtask

  task automatic t_nchange();
    n_m = 12;
    wait_m("R6");
    chk(ln_m, 8, "R6 straddling report keeps old N");
    chk(lc_m, 20, "R6 straddling report keeps old period");
    wait_m("R6");
    chk(ln_m, 12, "R6 new N after wrap");
    chk(lc_m, 30, "R6 new period after wrap");
  endtask

  task automatic t_nzero();
    n_m = 0;
    for (int i = 0; i < 4; i++) wait_m("R7");
    chk(ln_m, 1, "R7 zero N reported as 1");
    chk_rng(lc_m, 2, 3, "R7 zero N divides by 1");
  endtask

  task automatic t_disable();
    int s0;
    en_m = 1'b0;
    s0 = str_m;
    step(100);
    chk(str_m - s0, 0, "R9 no report while disabled");
    chk(val_m, 0, "R9 strobe low while disabled");
    n_m = 8;
    en_m = 1'b1;
    s0 = str_m;
    step(35);
    chk(str_m - s0, 0, "R9 re-enable discards first edge");
    wait_m("R9");
    chk(lc_m, 20, "R9 period after re-enable");
  endtask

  task automatic t_sat();
    n_s = 200;
    en_s = 1'b1;
    wait_s("R8");
    chk(lc_s, 255, "R8 overrun saturates");
    chk(le_s, 1, "R8 overrun flagged");
    n_s = 102;
    wait_s("R8");
    wait_s("R8");
    chk(lc_s, 255, "R8 exact full-scale period");
    chk(le_s, 0, "R8 exact full scale not flagged");
    chk(ln_s, 102, "R8 n_used at full scale");
    n_s = 101;
    wait_s("R8");
    wait_s("R8");
    chk_rng(lc_s, 252, 253, "R8 in-range period");
    chk(le_s, 0, "R8 flag stays clear");
  endtask

  task automatic t_async();
    longint sum = 0;
    en_m = 1'b0;
    step(20);
    ref_half = 3.65;
    n_m = 10;
    step(20);
    en_m = 1'b1;
    wait_m("R4");
    chk_rng(lc_m, 18, 19, "R4 async first report");
    for (int i = 0; i < 4; i++) begin
      wait_m("R4");
      chk_rng(lc_m, 18, 19, "R4 async report floor/ceil");
      sum += lc_m;
    end
    chk_rng(sum, 72, 74, "R4 async four-period sum");
  endtask

  initial begin
    en_m = 1'b0; n_m = 8;
    en_s = 1'b0; n_s = 200;
    rst_n = 1'b0;
    step(10);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_first();
    t_nchange();
    t_nzero();
    t_disable();
    t_sat();
    t_async();
    chk(dbl, 0, "R5 strobe never two cycles wide");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge lnk_clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d cycles", 100000, 0);
    finish_run();
  end
endmodule